// File: doc/BRIEF.md
# Oversampled Clock Recovery Loop with Holdover

This block rebuilds a bit-rate clock enable from a stream of single-cycle pulse strobes, running on a clock at sixteen times the nominal bit rate. A numerically controlled phase register advances by a programmable rate word on every fast cycle. Its top four bits give the position inside the current bit, from 0 to 15. When the register wraps, one bit period ends: the block emits a one-cycle clock enable and the retimed data bit for the window that just closed. A pulse should land at position 8. A pulse that lands earlier or later moves the phase by one sixteenth of a bit at most once per bit, and nudges the rate word by one least-significant step.

A loss-of-signal input stops the tracking, but the clock enable keeps running. The holdover-select input picks one of two behaviours. In holdover the rate word learned during tracking stays frozen. In the other mode the rate word moves by one step per bit towards a nominal rate word supplied on an input, so the frequency changes gradually and never jumps.

A three-state machine holds the mode. TRACK follows the pulses. HOLD freezes the rate. SLEW walks the rate towards the nominal word. The transitions are:
- TRACK→HOLD when loss rises with holdover selected.
- TRACK→SLEW when loss rises without holdover selected.
- HOLD→SLEW and SLEW→HOLD when the select input changes during loss.
- HOLD→TRACK and SLEW→TRACK one cycle after loss clears.

Top module: `clk_recovery`

## Requirements
- R1: While reset is low, `rclk_en_o` and `rdata_o` are 0. The phase is 0 and the rate word is 2^FRAC_W, which is one phase count per cycle. The first clock enable is high in the 16th cycle after reset is released.
- R2: In TRACK with no pulses and the reset rate word, a clock enable appears every 16 cycles and `rdata_o` is 0 at each enable.
- R3: A pulse arriving when the phase position is 0–7 (early) makes the phase advance by the rate word plus one full count in that cycle. The rate word is one step larger from the next cycle on.
- R4: A pulse arriving when the phase position is 9–15 (late) leaves the phase unchanged in that cycle. The rate word is one step smaller from the next cycle on.
- R5: A pulse at phase position 8 changes neither the phase nor the rate word.
- R6: At most one correction is made per bit period. Further pulses before the next wrap have no effect on the phase.
- R7: At every clock enable, `rdata_o` is 1 if and only if at least one pulse arrived during the bit period that just ended. This includes a pulse in the wrap cycle itself, and it holds in every state.
- R8: In HOLD, the rate word does not change and pulses do not move the phase. The enable rate equals the rate learned before the loss.
- R9: In SLEW, the rate word changes only in wrap cycles. It moves by exactly one step towards `ref_rate_i` and stops when it equals that word.
- R10: One cycle after `los_i` falls, the state is TRACK and pulse corrections resume.
- R11: `rclk_en_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock at 16x the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 1 | One-cycle strobe for each received line pulse |
| los_i | input | 1 | Loss-of-signal flag |
| hold_sel_i | input | 1 | 1: freeze the learned rate during loss; 0: slew to `ref_rate_i` |
| ref_rate_i | input | FRAC_W+1 | Nominal rate word (phase counts per cycle, FRAC_W fraction bits) |
| rclk_en_o | output | 1 | Recovered clock enable, one cycle per bit |
| rdata_o | output | 1 | Retimed data bit, valid while `rclk_en_o` is high |

## Verification
A single pulse is swept over all sixteen phase positions from a freshly reset loop. The length of the following bit period separates early, centred and late corrections, and the arithmetic model of the phase register also exposes the one-step rate update. Two pulses inside one bit show whether a second correction leaks through. A long run of early pulses trains the rate word to a known value. Counting enables over a fixed window then shows whether HOLD froze that value and whether SLEW settles on nominal words below and above it. Pulses sent during HOLD, compared with the same pulse after loss clears, show that corrections are blocked and then resumed.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

    typedef enum logic [1:0] {
        ST_TRACK = 2'd0,
        ST_HOLD  = 2'd1,
        ST_SLEW  = 2'd2
    } cdr_state_e;

    typedef enum logic [1:0] {
        CORR_NONE = 2'd0,
        CORR_ADV  = 2'd1,
        CORR_RET  = 2'd2
    } corr_e;

endpackage

// File: rtl/cdr_phase_nco.sv
module cdr_phase_nco
    import cdr_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_i,
    input  logic              track_en_i,
    input  logic [FRAC_W:0]   rate_i,
    output logic              carry_o,
    output corr_e             corr_o
);
    localparam int PW  = FRAC_W + 4;
    localparam int MID = 8;
    localparam logic [PW:0] ONE = {4'b0000, 1'b1, {FRAC_W{1'b0}}};

    logic [PW-1:0] phase_q;
    logic          done_q;
    logic [3:0]    whole;
    logic [PW:0]   sum;
    logic [PW:0]   rate_ext;

    always_comb begin
        whole    = phase_q[PW-1 -: 4];
        rate_ext = {{(PW-FRAC_W){1'b0}}, rate_i};
        corr_o   = CORR_NONE;
        if (pulse_i && track_en_i && !done_q) begin
            if (whole < 4'(MID)) begin
                corr_o = CORR_ADV;
            end else if (whole > 4'(MID)) begin
                corr_o = CORR_RET;
            end
        end
        unique case (corr_o)
            CORR_ADV: sum = {1'b0, phase_q} + rate_ext + ONE;
            CORR_RET: sum = {1'b0, phase_q};
            default:  sum = {1'b0, phase_q} + rate_ext;
        endcase
        carry_o = sum[PW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            done_q  <= 1'b0;
        end else begin
            phase_q <= sum[PW-1:0];
            if (carry_o) begin
                done_q <= 1'b0;
            end else if (corr_o != CORR_NONE) begin
                done_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cdr_rate_ctl.sv
module cdr_rate_ctl
    import cdr_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              los_i,
    input  logic              hold_sel_i,
    input  logic [FRAC_W:0]   ref_rate_i,
    input  logic              carry_i,
    input  corr_e             corr_i,
    output cdr_state_e        state_o,
    output logic [FRAC_W:0]   rate_o
);
    localparam int RW = FRAC_W + 1;
    localparam logic [RW-1:0] NOM  = {1'b1, {FRAC_W{1'b0}}};
    localparam logic [RW-1:0] RMAX = {RW{1'b1}};
    localparam logic [RW-1:0] RMIN = RW'(1);

    cdr_state_e    state_q, state_d;
    logic [RW-1:0] rate_q, rate_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_TRACK;
            rate_q  <= NOM;
        end else begin
            state_q <= state_d;
            rate_q  <= rate_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TRACK: if (los_i) state_d = hold_sel_i ? ST_HOLD : ST_SLEW;
            ST_HOLD: begin
                if (!los_i)          state_d = ST_TRACK;
                else if (!hold_sel_i) state_d = ST_SLEW;
            end
            ST_SLEW: begin
                if (!los_i)          state_d = ST_TRACK;
                else if (hold_sel_i) state_d = ST_HOLD;
            end
            default: state_d = ST_TRACK;
        endcase
    end

    // rate word per state
    always_comb begin
        rate_d = rate_q;
        unique case (state_q)
            ST_TRACK: begin
                if (corr_i == CORR_ADV && rate_q != RMAX) rate_d = rate_q + 1'b1;
                else if (corr_i == CORR_RET && rate_q != RMIN) rate_d = rate_q - 1'b1;
            end
            ST_HOLD: rate_d = rate_q;
            ST_SLEW: begin
                if (carry_i) begin
                    if (rate_q < ref_rate_i)      rate_d = rate_q + 1'b1;
                    else if (rate_q > ref_rate_i) rate_d = rate_q - 1'b1;
                end
            end
            default: rate_d = rate_q;
        endcase
    end

    assign state_o = state_q;
    assign rate_o  = rate_q;

endmodule

// File: rtl/cdr_retime.sv
module cdr_retime (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    input  logic carry_i,
    output logic tick_o,
    output logic data_o
);
    logic hit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            tick_o <= 1'b0;
            data_o <= 1'b0;
        end else begin
            tick_o <= carry_i;
            if (carry_i) begin
                data_o <= hit_q | pulse_i;
                hit_q  <= 1'b0;
            end else if (pulse_i) begin
                hit_q  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/clk_recovery.sv
module clk_recovery
    import cdr_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pulse_i,
    input  logic            los_i,
    input  logic            hold_sel_i,
    input  logic [FRAC_W:0] ref_rate_i,
    output logic            rclk_en_o,
    output logic            rdata_o
);
    cdr_state_e      state_w;
    corr_e           corr_w;
    logic            carry_w;
    logic [FRAC_W:0] rate_w;
    logic            track_w;

    assign track_w = (state_w == ST_TRACK);

    cdr_phase_nco #(.FRAC_W(FRAC_W)) u_nco (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_i    (pulse_i),
        .track_en_i (track_w),
        .rate_i     (rate_w),
        .carry_o    (carry_w),
        .corr_o     (corr_w)
    );

    cdr_rate_ctl #(.FRAC_W(FRAC_W)) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .los_i      (los_i),
        .hold_sel_i (hold_sel_i),
        .ref_rate_i (ref_rate_i),
        .carry_i    (carry_w),
        .corr_i     (corr_w),
        .state_o    (state_w),
        .rate_o     (rate_w)
    );

    cdr_retime u_rt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (pulse_i),
        .carry_i (carry_w),
        .tick_o  (rclk_en_o),
        .data_o  (rdata_o)
    );

endmodule

// File: rtl/clk_recovery_chk.sv
module clk_recovery_chk
    import cdr_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic            carry,
    input logic            los,
    input cdr_state_e      state,
    input corr_e           corr,
    input logic [FRAC_W:0] rate,
    input logic [FRAC_W:0] ref_rate
);
    // R11
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R8
    hold_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> $stable(rate));

    // R9
    slew_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEW && !carry) |=> $stable(rate));

    // R9
    slew_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEW && carry && rate < ref_rate) |=> (rate == $past(rate) + 1'b1));

    // R9
    slew_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEW && carry && rate > ref_rate) |=> (rate == $past(rate) - 1'b1));

    // R6
    one_corr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (corr != CORR_NONE) |=> (corr == CORR_NONE));

    // R8
    hold_nocorr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_TRACK) |-> (corr == CORR_NONE));

    // R10
    back_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!los && state != ST_TRACK) |=> (state == ST_TRACK));

endmodule

bind clk_recovery clk_recovery_chk #(.FRAC_W(FRAC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (rclk_en_o),
    .carry    (carry_w),
    .los      (los_i),
    .state    (state_w),
    .corr     (corr_w),
    .rate     (rate_w),
    .ref_rate (ref_rate_i)
);

// File: tb/sim_clk_recovery.sv
module sim_clk_recovery;
    localparam int CLK_PERIOD = 10;
    localparam int FW         = 8;
    localparam int UNIT       = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pulse_i = 1'b0;
    logic          los_i = 1'b0;
    logic          hold_sel_i = 1'b0;
    logic [FW:0]   ref_rate_i = 9'd256;
    logic          rclk_en_o;
    logic          rdata_o;

    int n_run  = 0;
    int n_fail = 0;

    clk_recovery #(.FRAC_W(FW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_i    (pulse_i),
        .los_i      (los_i),
        .hold_sel_i (hold_sel_i),
        .ref_rate_i (ref_rate_i),
        .rclk_en_o  (rclk_en_o),
        .rdata_o    (rdata_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // bit length in cycles after a tick with zero phase, one pulse at position k
    function automatic int exp_gap(input int k, input int rate0);
        int ph = 0;
        int r  = rate0;
        for (int m = 0; m < 64; m++) begin
            if (m == k && k < 8) begin
                ph += r + 256;
                r++;
            end else if (m == k && k > 8) begin
                r--;
            end else begin
                ph += r;
            end
            if (ph >= UNIT) return m + 1;
        end
        return -1;
    endfunction

    task automatic do_reset();
        rst_n      = 1'b0;
        pulse_i    = 1'b0;
        los_i      = 1'b0;
        hold_sel_i = 1'b0;
        ref_rate_i = 9'd256;
        repeat (3) @(negedge clk);
        chk(rclk_en_o == 1'b0, "R1 enable in reset", int'(rclk_en_o), 0);
        chk(rdata_o == 1'b0, "R1 data in reset", int'(rdata_o), 0);
        rst_n = 1'b1;
    endtask

    // cycles until next tick; pulses at positions k1/k2 (-1: none)
    task automatic run_bit(input int k1, input int k2, output int n);
        n = 0;
        pulse_i = (k1 == 0 || k2 == 0);
        do begin
            @(negedge clk);
            n++;
            pulse_i = (n == k1 || n == k2);
        end while (!rclk_en_o && n < 64);
        pulse_i = 1'b0;
    endtask

    task automatic count_ticks(input int cycles, output int c);
        c = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (rclk_en_o) c++;
        end
    endtask

    initial begin
        int n;
        int c;
        int mn;
        int mx;

        // R1, R2: reset and free running
        do_reset();
        run_bit(-1, -1, n);
        chk(n == 16, "R1 first tick", n, 16);
        for (int b = 0; b < 3; b++) begin
            run_bit(-1, -1, n);
            chk(n == 16, "R2 idle period", n, 16);
            chk(rdata_o == 1'b0, "R2 idle data", int'(rdata_o), 0);
        end

        // R3 R4 R5 R7: sweep a single pulse over every phase position
        for (int k = 0; k < 16; k++) begin
            do_reset();
            run_bit(-1, -1, n);
            run_bit(k, -1, n);
            chk(n == exp_gap(k, 256),
                (k < 8) ? "R3 early pulse" : ((k == 8) ? "R5 centred pulse" : "R4 late pulse"),
                n, exp_gap(k, 256));
            chk(rdata_o == 1'b1, "R7 pulse bit", int'(rdata_o), 1);
            run_bit(-1, -1, n);
            chk(rdata_o == 1'b0, "R7 empty bit", int'(rdata_o), 0);
        end

        // R6: second pulse in the same bit is not corrected
        do_reset();
        run_bit(-1, -1, n);
        run_bit(2, 5, n);
        chk(n == exp_gap(2, 256), "R6 one correction", n, exp_gap(2, 256));

        // train rate word to 288 with early pulses
        do_reset();
        run_bit(-1, -1, n);
        for (int b = 0; b < 32; b++) run_bit(4, -1, n);

        // R8: holdover keeps learned rate
        los_i      = 1'b1;
        hold_sel_i = 1'b1;
        count_ticks(UNIT, c);
        chk(c >= 287 && c <= 289, "R8 holdover rate", c, 288);

        // R9: slew down to 256, no abrupt change
        hold_sel_i = 1'b0;
        ref_rate_i = 9'd256;
        run_bit(-1, -1, n);
        mn = 99;
        mx = 0;
        for (int b = 0; b < 64; b++) begin
            run_bit(-1, -1, n);
            if (n < mn) mn = n;
            if (n > mx) mx = n;
        end
        chk(mn >= 14 && mx <= 17, "R9 smooth slew max", mx, 16);
        chk(mn >= 14, "R9 smooth slew min", mn, 14);
        count_ticks(UNIT, c);
        chk(c >= 255 && c <= 257, "R9 slew settles low", c, 256);

        // R9 up to 320, R11 spacing
        ref_rate_i = 9'd320;
        mn = 99;
        for (int b = 0; b < 100; b++) begin
            run_bit(-1, -1, n);
            if (n < mn) mn = n;
        end
        chk(mn > 1, "R11 enable spacing", mn, 12);
        count_ticks(UNIT, c);
        chk(c >= 319 && c <= 321, "R9 slew settles high", c, 320);

        // back to 256, then hold and try to disturb
        ref_rate_i = 9'd256;
        for (int b = 0; b < 100; b++) run_bit(-1, -1, n);
        hold_sel_i = 1'b1;
        run_bit(-1, -1, n);
        run_bit(2, -1, n);
        chk(n == 16, "R8 pulse ignored in hold", n, 16);
        chk(rdata_o == 1'b1, "R7 data kept in hold", int'(rdata_o), 1);
        run_bit(-1, -1, n);
        chk(n == 16, "R8 phase undisturbed", n, 16);

        // R10: release loss, corrections resume
        los_i = 1'b0;
        run_bit(-1, -1, n);
        chk(n == 16, "R10 after release", n, 16);
        run_bit(2, -1, n);
        chk(n == 14 || n == 15, "R10 correction resumes", n, 15);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule